// File: doc/BRIEF.md
# Vector Element High/Low Multiplier

This block multiplies one pair of integer vector elements, each `SEW` bits wide. An operation code selects the result. It can be the low `SEW` bits of the product, or the upper `SEW` bits of the full `2*SEW`-bit product. The upper half is available with both operands signed, both unsigned, or a mixed form in which operand A is signed and operand B is unsigned.

Both operands are widened by one bit, using sign or zero fill as the operation code requires. A single signed multiplier of width `SEW+1` therefore serves all four operations. The product and the operation code then pass through a pipeline of `LATENCY` registers. The output stage picks the requested half.

A vector unit can issue one element every cycle. Each result appears a fixed number of cycles after its input, marked by a valid strobe.

Top module: `vmhl_mul`

## Requirements
- R1: With `in_op` = 0 (low), `out_data` equals bits [SEW-1:0] of `opnd_a` × `opnd_b`. These bits are the same whether the operands are read as signed or unsigned.
- R2: With `in_op` = 1 (high, signed×signed), `out_data` equals bits [2*SEW-1:SEW] of the two's-complement product of both operands taken as signed.
- R3: With `in_op` = 2 (high, unsigned×unsigned), `out_data` equals bits [2*SEW-1:SEW] of the product of both operands taken as unsigned.
- R4: With `in_op` = 3 (high, mixed), `out_data` equals bits [2*SEW-1:SEW] of the product of signed `opnd_a` and unsigned `opnd_b`.
- R5: `out_valid` is high in a cycle exactly when `in_valid` was high `LATENCY` clock edges earlier. Back-to-back inputs give back-to-back results, and a cycle without `in_valid` gives a cycle without `out_valid`.
- R6: Whenever `out_valid` is low, `out_data` is zero.
- R7: While `rst_n` is low, `out_valid` and `out_data` are both zero. Reset takes effect without a clock. Its release is synchronised to `clk` through two flops, so inputs are accepted from the third rising edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair present this cycle |
| in_op | input | 2 | 0 low, 1 high signed, 2 high unsigned, 3 high signed×unsigned |
| opnd_a | input | SEW | Operand A (signed in the mixed form) |
| opnd_b | input | SEW | Operand B (unsigned in the mixed form) |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | SEW | Selected half of the product |

## Verification
On every cycle, the bound checker compares `out_valid` with a shadow of `in_valid` delayed by `LATENCY` edges. It checks each result half against its own product, computed separately for each operation. It also enforces the zero output when idle and during reset.

The behaviour of the synchronised reset release and the exact count of edges from a lone input pulse to its result are shown only by the bench's scenarios. The same holds for an exhaustive operand sweep with bubbles at `SEW` = 6 and for an explicit pass over the operands 0, 1, all-ones and most-negative in every mode.

// File: rtl/vmhl_pkg.sv
package vmhl_pkg;

  typedef enum logic [1:0] {
    VMHL_LO  = 2'd0,
    VMHL_HSS = 2'd1,
    VMHL_HUU = 2'd2,
    VMHL_HSU = 2'd3
  } vmhl_op_e;

  // operand A is sign-filled for every form except the unsigned high one
  function automatic logic a_is_signed(vmhl_op_e op);
    return (op != VMHL_HUU);
  endfunction

  // operand B is sign-filled only for the low and signed-high forms
  function automatic logic b_is_signed(vmhl_op_e op);
    return (op == VMHL_LO) || (op == VMHL_HSS);
  endfunction

endpackage

// File: rtl/vmhl_rst_sync.sv
module vmhl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q, meta_d;
  logic hold_q, hold_d;

  always_comb begin
    meta_d = 1'b1;
    hold_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= meta_d;
      hold_q <= hold_d;
    end
  end

  assign rst_sync_n = hold_q;

endmodule

// File: rtl/vmhl_extend.sv
module vmhl_extend
  import vmhl_pkg::*;
#(
  parameter int SEW = 16
) (
  input  vmhl_op_e          op,
  input  logic [SEW-1:0]    a,
  input  logic [SEW-1:0]    b,
  output logic [2*SEW-1:0]  prod
);

  localparam int XW = SEW + 1;
  localparam int PW = 2 * SEW;

  logic [XW-1:0] a_x, b_x;
  logic [PW-1:0] a_w, b_w;

  // one extra bit per operand: sign fill or zero fill per form
  always_comb begin
    a_x = {a_is_signed(op) & a[SEW-1], a};
    b_x = {b_is_signed(op) & b[SEW-1], b};
  end

  // widen to product width by replicating the extension bit, then a single
  // multiplier modulo 2^(2*SEW) gives the exact low 2*SEW product bits
  always_comb begin
    a_w  = {{(PW-XW){a_x[XW-1]}}, a_x};
    b_w  = {{(PW-XW){b_x[XW-1]}}, b_x};
    prod = a_w * b_w;
  end

endmodule

// File: rtl/vmhl_pipe.sv
module vmhl_pipe #(
  parameter int W     = 34,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_dat,
  output logic         out_vld,
  output logic [W-1:0] out_dat
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_stg
    logic         v_d, v_q;
    logic [W-1:0] d_d, d_q;
    logic         ce;

    if (i == 0) begin : g_head
      assign v_d = in_vld;
      assign d_d = in_dat;
    end else begin : g_link
      assign v_d = g_stg[i-1].v_q;
      assign d_d = g_stg[i-1].d_q;
    end

    // payload register loads only when a valid item arrives
    assign ce = v_d;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_d;
    end

    always_ff @(posedge clk) begin
      if (ce) d_q <= d_d;
    end
  end

  assign out_vld = g_stg[DEPTH-1].v_q;
  assign out_dat = g_stg[DEPTH-1].d_q;

endmodule

// File: rtl/vmhl_select.sv
module vmhl_select
  import vmhl_pkg::*;
#(
  parameter int SEW = 16
) (
  input  logic              vld,
  input  vmhl_op_e          op,
  input  logic [2*SEW-1:0]  prod,
  output logic [SEW-1:0]    res
);

  logic [SEW-1:0] half;

  always_comb begin
    half = (op == VMHL_LO) ? prod[SEW-1:0] : prod[2*SEW-1:SEW];
    res  = vld ? half : '0;
  end

endmodule

// File: rtl/vmhl_mul.sv
module vmhl_mul
  import vmhl_pkg::*;
#(
  parameter int SEW     = 16,
  parameter int LATENCY = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [1:0]     in_op,
  input  logic [SEW-1:0] opnd_a,
  input  logic [SEW-1:0] opnd_b,
  output logic           out_valid,
  output logic [SEW-1:0] out_data
);

  localparam int PW = 2 * SEW;
  localparam int OW = 2;
  localparam int QW = PW + OW;

  logic           rst_sync_n;
  vmhl_op_e       op_in;
  logic [PW-1:0]  prod_in;
  logic [QW-1:0]  pl_in, pl_out;
  logic           pl_vld;
  vmhl_op_e       op_out;
  logic [PW-1:0]  prod_out;

  vmhl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign op_in = vmhl_op_e'(in_op);

  vmhl_extend #(.SEW(SEW)) u_ext (
    .op   (op_in),
    .a    (opnd_a),
    .b    (opnd_b),
    .prod (prod_in)
  );

  assign pl_in = {in_op, prod_in};

  vmhl_pipe #(.W(QW), .DEPTH(LATENCY)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .in_vld  (in_valid),
    .in_dat  (pl_in),
    .out_vld (pl_vld),
    .out_dat (pl_out)
  );

  assign op_out   = vmhl_op_e'(pl_out[QW-1:PW]);
  assign prod_out = pl_out[PW-1:0];

  vmhl_select #(.SEW(SEW)) u_sel (
    .vld  (pl_vld),
    .op   (op_out),
    .prod (prod_out),
    .res  (out_data)
  );

  assign out_valid = pl_vld;

endmodule

// File: rtl/vmhl_mul_chk.sv
module vmhl_mul_chk #(
  parameter int SEW     = 16,
  parameter int LATENCY = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rst_sync_n,
  input logic           in_valid,
  input logic [1:0]     in_op,
  input logic [SEW-1:0] opnd_a,
  input logic [SEW-1:0] opnd_b,
  input logic           out_valid,
  input logic [SEW-1:0] out_data
);

  localparam int PW = 2 * SEW;

  logic [PW-1:0]  a_sx, a_zx, b_sx, b_zx;
  logic [PW-1:0]  p_ss, p_uu, p_su;
  logic [SEW-1:0] exp_now;

  always_comb begin
    a_sx = {{SEW{opnd_a[SEW-1]}}, opnd_a};
    a_zx = {{SEW{1'b0}}, opnd_a};
    b_sx = {{SEW{opnd_b[SEW-1]}}, opnd_b};
    b_zx = {{SEW{1'b0}}, opnd_b};
    p_ss = a_sx * b_sx;
    p_uu = a_zx * b_zx;
    p_su = a_sx * b_zx;
    case (in_op)
      2'd0:    exp_now = SEW'(p_uu);
      2'd1:    exp_now = SEW'(p_ss >> SEW);
      2'd2:    exp_now = SEW'(p_uu >> SEW);
      default: exp_now = SEW'(p_su >> SEW);
    endcase
  end

  logic           sh_v  [LATENCY];
  logic [1:0]     sh_op [LATENCY];
  logic [SEW-1:0] sh_e  [LATENCY];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int i = 0; i < LATENCY; i++) begin
        sh_v[i]  <= 1'b0;
        sh_op[i] <= 2'd0;
        sh_e[i]  <= '0;
      end
    end else begin
      sh_v[0]  <= in_valid;
      sh_op[0] <= in_op;
      sh_e[0]  <= exp_now;
      for (int i = 1; i < LATENCY; i++) begin
        sh_v[i]  <= sh_v[i-1];
        sh_op[i] <= sh_op[i-1];
        sh_e[i]  <= sh_e[i-1];
      end
    end
  end

  assert_valid_latency_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid == sh_v[LATENCY-1]);

  assert_low_half_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sh_v[LATENCY-1] && sh_op[LATENCY-1] == 2'd0) |-> out_data == sh_e[LATENCY-1]);

  assert_high_ss_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sh_v[LATENCY-1] && sh_op[LATENCY-1] == 2'd1) |-> out_data == sh_e[LATENCY-1]);

  assert_high_uu_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sh_v[LATENCY-1] && sh_op[LATENCY-1] == 2'd2) |-> out_data == sh_e[LATENCY-1]);

  assert_high_su_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sh_v[LATENCY-1] && sh_op[LATENCY-1] == 2'd3) |-> out_data == sh_e[LATENCY-1]);

  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !out_valid |-> out_data == '0);

  always @(posedge clk) begin
    if (rst_n === 1'b0) begin
      assert_reset_quiet_R7: assert (!out_valid && out_data == '0);
    end
  end

endmodule

bind vmhl_mul vmhl_mul_chk #(.SEW(SEW), .LATENCY(LATENCY)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .in_valid   (in_valid),
  .in_op      (in_op),
  .opnd_a     (opnd_a),
  .opnd_b     (opnd_b),
  .out_valid  (out_valid),
  .out_data   (out_data)
);

// File: tb/vmhl_mul_bench.sv
`timescale 1ns/1ps
module vmhl_mul_bench;

  localparam int SEW  = 6;
  localparam int LAT  = 3;
  localparam longint FULL = longint'(1) << SEW;
  localparam longint HALF = longint'(1) << (SEW - 1);
  localparam longint MASK = FULL - 1;

  logic           clk;
  logic           rst_n;
  logic           in_valid;
  logic [1:0]     in_op;
  logic [SEW-1:0] opnd_a, opnd_b;
  logic           out_valid;
  logic [SEW-1:0] out_data;

  int total = 0;
  int bad   = 0;

  vmhl_mul #(.SEW(SEW), .LATENCY(LAT)) u_vmhl_mul (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  typedef struct { bit v; int op; longint e; } exp_t;
  exp_t q[$];

  function automatic longint ref_mul(int op, longint a, longint b);
    longint sa = (a >= HALF) ? a - FULL : a;
    longint sb = (b >= HALF) ? b - FULL : b;
    case (op)
      0:       return (sa * sb) & MASK;
      1:       return ((sa * sb) >>> SEW) & MASK;
      2:       return ((a * b) >>> SEW) & MASK;
      default: return ((sa * b) >>> SEW) & MASK;
    endcase
  endfunction

  function automatic string op_tag(int op);
    case (op)
      0:       return "R1";
      1:       return "R2";
      2:       return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one negedge: compare the item issued LAT cycles ago, then issue a new one
  task automatic step(bit v, int op, longint a, longint b);
    exp_t x;
    @(negedge clk);
    if (q.size() == LAT) begin
      x = q.pop_front();
      check(out_valid == x.v, "R5", "valid", longint'(out_valid), longint'(x.v));
      if (x.v)
        check(longint'(out_data) == x.e, op_tag(x.op), "data", longint'(out_data), x.e);
      else
        check(out_data == '0, "R6", "idle data", longint'(out_data), 0);
    end
    in_valid = v;
    in_op    = op[1:0];
    opnd_a   = a[SEW-1:0];
    opnd_b   = b[SEW-1:0];
    x.v  = v;
    x.op = op;
    x.e  = v ? ref_mul(op, a, b) : 0;
    q.push_back(x);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL R5 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat_seen;
    longint corner [4];
    rst_n = 1'b0; in_valid = 1'b0; in_op = 2'd0; opnd_a = '0; opnd_b = '0;

    // R7: quiet outputs during reset, even with valid inputs offered
    repeat (3) begin
      @(negedge clk);
      in_valid = 1'b1;
      check(out_valid == 1'b0, "R7", "valid in reset", longint'(out_valid), 0);
      check(out_data == '0, "R7", "data in reset", longint'(out_data), 0);
    end
    in_valid = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R7", "valid after release", longint'(out_valid), 0);

    // R5: lone pulse, count edges to the result
    in_valid = 1'b1; in_op = 2'd2; opnd_a = 6'd63; opnd_b = 6'd63;
    @(negedge clk) in_valid = 1'b0;
    lat_seen = 1;
    while (!out_valid && lat_seen < 20) begin
      @(negedge clk);
      lat_seen++;
    end
    check(lat_seen == LAT, "R5", "latency", lat_seen, LAT);
    check(longint'(out_data) == 62, "R3", "63x63 high", longint'(out_data), 62);
    @(negedge clk);
    check(out_valid == 1'b0, "R5", "single result", longint'(out_valid), 0);

    // exhaustive sweep, bubble every seventh item
    for (int k = 0; k < 4 * FULL * FULL; k++) begin
      if (k % 7 == 6) step(1'b0, 0, k % FULL, 5);
      step(1'b1, k / int'(FULL * FULL), (k / int'(FULL)) % FULL, k % FULL);
    end

    // corners 0, 1, all-ones, most-negative in every mode (R1 R2 R3 R4)
    corner[0] = 0; corner[1] = 1; corner[2] = MASK; corner[3] = HALF;
    for (int op = 0; op < 4; op++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          step(1'b1, op, corner[i], corner[j]);

    repeat (LAT + 1) step(1'b0, 0, 0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule